// File: doc/BRIEF.md
# Taint-Tracking Integer Execution Slice

This block is a small integer execution slice whose general-purpose registers each hold one extra token bit that marks the value as untrusted. It takes one decoded micro-operation per cycle. It reads its register operands, computes a result together with the result's token, and writes the destination register. Compares write a pair of predicate bits. Memory-address issue, branch-register moves and token checks are reported on registered outputs. When an op breaks the taint policy, the slice raises a fault with a cause code.

Taint moves through arithmetic as the OR of the source tokens. A few idioms override that OR: an XOR or SUB of a register with itself, explicit set-tag and clear-tag ops, and loads that take their token from the incoming load tag. A per-op relax flag selects taint-aware behaviour for compares and for memory-address use. It does not affect moves into the branch register, which always trap when the source is tainted. Spill and fill ops save and restore data together with its token in a small side store indexed by slot.

Top module: `tte_slice`

## Requirements
- R1: ADD (op_code 0), SUB (1), AND (2), OR (3) and XOR (4) write rd with the arithmetic result, and the result token is the OR of the two source tokens.
- R2: An XOR or SUB whose rs1 equals rs2 writes zero data with a clear token, whatever the source token.
- R3: A compare (CMPEQ op_code 5, unsigned CMPLT op_code 6) without relax writes 0 to both predicates op_pd_t and op_pd_f when either source token is set. Otherwise it writes the comparison to op_pd_t and its inverse to op_pd_f.
- R4: A compare carrying op_relax writes both predicates from the real comparison even when a source is tainted.
- R5: LOAD (9) writes ld_data to rd with token ld_tag OR the address token, and STORE (10) issues mem_addr = rs1 data, st_data/st_tag = rs2 data and token. If the rs1 token is set and op_relax is clear, either op instead raises fault_cause 1 (consumption) and issues nothing.
- R6: MOVBR (11) pulses br_wr with rs1 data when rs1 is untainted. When rs1 is tainted it raises fault_cause 2 (violation), even with op_relax set.
- R7: SETTAG (7) writes rd with zero data and a set token, and CLRTAG (8) writes rd with rs1 data and a clear token.
- R8: CHECK (12) pulses redirect for one cycle exactly when the rs1 token is set, and writes no register.
- R9: SPILL (13) stores rs1 data and token into side slot op_slot, and FILL (14) writes rd from that slot with both restored. LOAD never reads the side slots.
- R10: Register 0 always reads as zero with a clear token, and writes to it are discarded and not reported on wb_valid.
- R11: A fault is a one-cycle fault_valid pulse with fault_cause (1 consumption, 2 violation, else 0). The faulting op changes no register and raises no wb_valid, mem_valid or br_wr.
- R12: Every output is registered and reflects the op of the preceding clock edge. After reset all registers, predicates and pulses are zero, and an idle cycle (op_valid low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Micro-op present this cycle |
| op_code | input | 4 | Operation code |
| op_relax | input | 1 | Taint-aware behaviour for this op |
| op_rd | input | AW | Destination register |
| op_rs1 | input | AW | First source / address register |
| op_rs2 | input | AW | Second source / store data register |
| op_pd_t | input | PW | Predicate written with the compare result |
| op_pd_f | input | PW | Predicate written with the inverted result |
| op_slot | input | SW | Side slot for spill and fill |
| ld_data | input | DW | Load data |
| ld_tag | input | 1 | Load data token |
| wb_valid | output | 1 | Register written last cycle |
| wb_idx | output | AW | Written register |
| wb_data | output | DW | Written data |
| wb_tag | output | 1 | Written token |
| pred_vec | output | NPRED | Predicate register contents |
| mem_valid | output | 1 | Memory access issued |
| mem_store | output | 1 | Issued access is a store |
| mem_addr | output | DW | Access address |
| st_data | output | DW | Store data |
| st_tag | output | 1 | Store data token |
| br_wr | output | 1 | Branch register written |
| br_data | output | DW | Value moved to the branch register |
| redirect | output | 1 | Token check hit |
| fault_valid | output | 1 | Fault pulse |
| fault_cause | output | 2 | Fault cause code |

## Verification
The bench builds the slice with 32-bit data, sixteen registers, eight predicates, four side slots and the unsigned compare variant. With only sixteen registers, every operand can be given a distinct, known value and token, and register 0 can be written directly. With eight predicates, a tainted compare can overwrite predicates that an earlier compare had set to one. Four slots let a spilled tainted value sit beside untouched slots while a plain load runs between the spill and the fill.

// File: rtl/tte_pkg.sv
package tte_pkg;
   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_AND    = 4'd2,
      OP_OR     = 4'd3,
      OP_XOR    = 4'd4,
      OP_CMPEQ  = 4'd5,
      OP_CMPLT  = 4'd6,
      OP_SETTAG = 4'd7,
      OP_CLRTAG = 4'd8,
      OP_LOAD   = 4'd9,
      OP_STORE  = 4'd10,
      OP_MOVBR  = 4'd11,
      OP_CHECK  = 4'd12,
      OP_SPILL  = 4'd13,
      OP_FILL   = 4'd14
   } op_e;

   localparam logic [1:0] CAUSE_NONE    = 2'd0;
   localparam logic [1:0] CAUSE_CONSUME = 2'd1;
   localparam logic [1:0] CAUSE_VIOLATE = 2'd2;
endpackage

// File: rtl/tte_regfile.sv
module tte_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 16,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [DW-1:0] rd1,
   output logic          rt1,
   output logic [DW-1:0] rd2,
   output logic          rt2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic          wt
);
   logic [DW-1:0] data_q [NREG];
   logic          tag_q  [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            data_q[i] <= '0;
            tag_q[i]  <= 1'b0;
         end
      end else if (we && (wa != '0)) begin
         data_q[wa] <= wd;
         tag_q[wa]  <= wt;
      end
   end

   // register 0 is hardwired: zero data, clear token
   assign rd1 = (ra1 == '0) ? '0   : data_q[ra1];
   assign rt1 = (ra1 == '0) ? 1'b0 : tag_q[ra1];
   assign rd2 = (ra2 == '0) ? '0   : data_q[ra2];
   assign rt2 = (ra2 == '0) ? 1'b0 : tag_q[ra2];
endmodule

// File: rtl/tte_spill.sv
module tte_spill #(
   parameter int DW    = 32,
   parameter int NSLOT = 4,
   localparam int SW   = $clog2(NSLOT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] slot,
   input  logic [DW-1:0] wd,
   input  logic          wt,
   output logic [DW-1:0] rd,
   output logic          rt
);
   logic [DW-1:0] sd_q [NSLOT];
   logic          st_q [NSLOT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSLOT; i++) begin
            sd_q[i] <= '0;
            st_q[i] <= 1'b0;
         end
      end else if (we) begin
         sd_q[slot] <= wd;
         st_q[slot] <= wt;
      end
   end

   assign rd = sd_q[slot];
   assign rt = st_q[slot];
endmodule

// File: rtl/tte_alu.sv
module tte_alu import tte_pkg::*; #(
   parameter int DW         = 32,
   parameter bit CMP_SIGNED = 1'b0
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic          ta,
   input  logic [DW-1:0] b,
   input  logic          tb,
   input  logic          same_src,
   input  logic [DW-1:0] ld_data,
   input  logic          ld_tag,
   input  logic [DW-1:0] fill_d,
   input  logic          fill_t,
   output logic [DW-1:0] res,
   output logic          res_t,
   output logic          cmp
);
   logic lt;

   generate
      if (CMP_SIGNED) begin : g_lt_signed
         assign lt = $signed(a) < $signed(b);
      end else begin : g_lt_unsigned
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      res   = '0;
      res_t = ta | tb;
      unique case (op)
         OP_ADD: res = a + b;
         OP_SUB: begin
            res   = same_src ? '0 : a - b;
            res_t = same_src ? 1'b0 : (ta | tb);
         end
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: begin
            res   = same_src ? '0 : a ^ b;
            res_t = same_src ? 1'b0 : (ta | tb);
         end
         OP_SETTAG: begin
            res   = '0;
            res_t = 1'b1;
         end
         OP_CLRTAG: begin
            res   = a;
            res_t = 1'b0;
         end
         OP_LOAD: begin
            res   = ld_data;
            res_t = ld_tag | ta;
         end
         OP_FILL: begin
            res   = fill_d;
            res_t = fill_t;
         end
         default: begin
            res   = '0;
            res_t = 1'b0;
         end
      endcase
   end

   assign cmp = (op == OP_CMPLT) ? lt : (a == b);
endmodule

// File: rtl/tte_policy.sv
module tte_policy import tte_pkg::*; (
   input  logic       valid,
   input  op_e        op,
   input  logic       relax,
   input  logic       ta,
   input  logic       tb,
   input  logic       cmp,
   output logic       wr_reg,
   output logic       pred_we,
   output logic       pt_val,
   output logic       pf_val,
   output logic       mem_issue,
   output logic       br_issue,
   output logic       chk_hit,
   output logic       spill_we,
   output logic       fault,
   output logic [1:0] cause
);
   always_comb begin
      wr_reg    = 1'b0;
      pred_we   = 1'b0;
      pt_val    = 1'b0;
      pf_val    = 1'b0;
      mem_issue = 1'b0;
      br_issue  = 1'b0;
      chk_hit   = 1'b0;
      spill_we  = 1'b0;
      fault     = 1'b0;
      cause     = CAUSE_NONE;
      if (valid) begin
         unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_SETTAG, OP_CLRTAG, OP_FILL: wr_reg = 1'b1;
            OP_CMPEQ, OP_CMPLT: begin
               pred_we = 1'b1;
               if ((ta | tb) && !relax) begin
                  pt_val = 1'b0;
                  pf_val = 1'b0;
               end else begin
                  pt_val = cmp;
                  pf_val = !cmp;
               end
            end
            OP_LOAD, OP_STORE: begin
               if (ta && !relax) begin
                  fault = 1'b1;
                  cause = CAUSE_CONSUME;
               end else if (op == OP_LOAD) begin
                  wr_reg    = 1'b1;
                  mem_issue = 1'b1;
               end else begin
                  mem_issue = 1'b1;
               end
            end
            OP_MOVBR: begin
               if (ta) begin
                  fault = 1'b1;
                  cause = CAUSE_VIOLATE;
               end else begin
                  br_issue = 1'b1;
               end
            end
            OP_CHECK: chk_hit  = ta;
            OP_SPILL: spill_we = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tte_slice.sv
module tte_slice import tte_pkg::*; #(
   parameter int DW         = 32,
   parameter int NREG       = 16,
   parameter int NPRED      = 8,
   parameter int NSLOT      = 4,
   parameter bit CMP_SIGNED = 1'b0,
   localparam int AW        = $clog2(NREG),
   localparam int PW        = $clog2(NPRED),
   localparam int SW        = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic             op_relax,
   input  logic [AW-1:0]    op_rd,
   input  logic [AW-1:0]    op_rs1,
   input  logic [AW-1:0]    op_rs2,
   input  logic [PW-1:0]    op_pd_t,
   input  logic [PW-1:0]    op_pd_f,
   input  logic [SW-1:0]    op_slot,
   input  logic [DW-1:0]    ld_data,
   input  logic             ld_tag,
   output logic             wb_valid,
   output logic [AW-1:0]    wb_idx,
   output logic [DW-1:0]    wb_data,
   output logic             wb_tag,
   output logic [NPRED-1:0] pred_vec,
   output logic             mem_valid,
   output logic             mem_store,
   output logic [DW-1:0]    mem_addr,
   output logic [DW-1:0]    st_data,
   output logic             st_tag,
   output logic             br_wr,
   output logic [DW-1:0]    br_data,
   output logic             redirect,
   output logic             fault_valid,
   output logic [1:0]       fault_cause
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("tte_slice: DW must be at least 8");
      end
      if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
         $error("tte_slice: NREG must be a power of two, at least 2");
      end
      if (NPRED < 2 || (1 << PW) != NPRED) begin : g_bad_npred
         $error("tte_slice: NPRED must be a power of two, at least 2");
      end
      if (NSLOT < 2 || (1 << SW) != NSLOT) begin : g_bad_nslot
         $error("tte_slice: NSLOT must be a power of two, at least 2");
      end
   endgenerate

   op_e           op;
   logic [DW-1:0] a, b, res, fill_d;
   logic          ta, tb, res_t, fill_t, cmp;
   logic          wr_reg, pred_we, pt_val, pf_val, mem_issue, br_issue;
   logic          chk_hit, spill_we, fault;
   logic [1:0]    cause;
   logic [NPRED-1:0] pred_q;

   assign op = op_e'(op_code);

   tte_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(op_rs1), .ra2(op_rs2),
      .rd1(a), .rt1(ta), .rd2(b), .rt2(tb),
      .we(wr_reg), .wa(op_rd), .wd(res), .wt(res_t)
   );

   tte_spill #(.DW(DW), .NSLOT(NSLOT)) u_spill (
      .clk(clk), .rst_n(rst_n),
      .we(spill_we), .slot(op_slot), .wd(a), .wt(ta),
      .rd(fill_d), .rt(fill_t)
   );

   tte_alu #(.DW(DW), .CMP_SIGNED(CMP_SIGNED)) u_alu (
      .op(op), .a(a), .ta(ta), .b(b), .tb(tb),
      .same_src(op_rs1 == op_rs2),
      .ld_data(ld_data), .ld_tag(ld_tag),
      .fill_d(fill_d), .fill_t(fill_t),
      .res(res), .res_t(res_t), .cmp(cmp)
   );

   tte_policy u_pol (
      .valid(op_valid), .op(op), .relax(op_relax),
      .ta(ta), .tb(tb), .cmp(cmp),
      .wr_reg(wr_reg), .pred_we(pred_we), .pt_val(pt_val), .pf_val(pf_val),
      .mem_issue(mem_issue), .br_issue(br_issue), .chk_hit(chk_hit),
      .spill_we(spill_we), .fault(fault), .cause(cause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_q      <= '0;
         wb_valid    <= 1'b0;
         wb_idx      <= '0;
         wb_data     <= '0;
         wb_tag      <= 1'b0;
         mem_valid   <= 1'b0;
         mem_store   <= 1'b0;
         mem_addr    <= '0;
         st_data     <= '0;
         st_tag      <= 1'b0;
         br_wr       <= 1'b0;
         br_data     <= '0;
         redirect    <= 1'b0;
         fault_valid <= 1'b0;
         fault_cause <= CAUSE_NONE;
      end else begin
         if (pred_we) begin
            pred_q[op_pd_f] <= pf_val;
            pred_q[op_pd_t] <= pt_val;
         end
         wb_valid <= wr_reg && (op_rd != '0);
         if (wr_reg) begin
            wb_idx  <= op_rd;
            wb_data <= res;
            wb_tag  <= res_t;
         end
         mem_valid <= mem_issue;
         if (mem_issue) begin
            mem_store <= (op == OP_STORE);
            mem_addr  <= a;
            st_data   <= b;
            st_tag    <= tb;
         end
         br_wr <= br_issue;
         if (br_issue) br_data <= a;
         redirect    <= chk_hit;
         fault_valid <= fault;
         fault_cause <= cause;
      end
   end

   assign pred_vec = pred_q;
endmodule

// File: rtl/tte_slice_chk.sv
module tte_slice_chk #(
   parameter int DW = 32,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic [3:0]    op_code,
   input logic [AW-1:0] op_rd,
   input logic [AW-1:0] op_rs1,
   input logic [AW-1:0] op_rs2,
   input logic          wb_valid,
   input logic [AW-1:0] wb_idx,
   input logic [DW-1:0] wb_data,
   input logic          wb_tag,
   input logic          mem_valid,
   input logic          br_wr,
   input logic          redirect,
   input logic          fault_valid,
   input logic [1:0]    fault_cause
);
   // R11
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (!wb_valid && !mem_valid && !br_wr && !redirect));

   // R11
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_cause == 2'd1 || fault_cause == 2'd2));

   // R10
   zero_reg_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_idx != '0));

   // R7
   settag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd7 && op_rd != '0)
      |=> (wb_valid && wb_tag && wb_data == '0));

   // R2
   self_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd4 || op_code == 4'd1) && op_rs1 == op_rs2 && op_rd != '0)
      |=> (wb_valid && !wb_tag && wb_data == '0));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!wb_valid && !mem_valid && !br_wr && !redirect && !fault_valid));
endmodule

bind tte_slice tte_slice_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
   .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_tag(wb_tag),
   .mem_valid(mem_valid), .br_wr(br_wr), .redirect(redirect),
   .fault_valid(fault_valid), .fault_cause(fault_cause)
);

// File: tb/tte_slice_test.sv
`timescale 1ns/1ps
module tte_slice_test;
   localparam int DW = 32, NREG = 16, NPRED = 8, NSLOT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        op_valid = 0, op_relax = 0, ld_tag = 0;
   logic [3:0]  op_code = 0, op_rd = 0, op_rs1 = 0, op_rs2 = 0;
   logic [2:0]  op_pd_t = 0, op_pd_f = 0;
   logic [1:0]  op_slot = 0;
   logic [31:0] ld_data = 0;
   logic        wb_valid, wb_tag, mem_valid, mem_store, st_tag, br_wr, redirect, fault_valid;
   logic [3:0]  wb_idx;
   logic [31:0] wb_data, mem_addr, st_data, br_data;
   logic [7:0]  pred_vec;
   logic [1:0]  fault_cause;

   tte_slice #(.DW(DW), .NREG(NREG), .NPRED(NPRED), .NSLOT(NSLOT)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_relax(op_relax), .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
      .op_pd_t(op_pd_t), .op_pd_f(op_pd_f), .op_slot(op_slot),
      .ld_data(ld_data), .ld_tag(ld_tag),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_tag(wb_tag),
      .pred_vec(pred_vec), .mem_valid(mem_valid), .mem_store(mem_store),
      .mem_addr(mem_addr), .st_data(st_data), .st_tag(st_tag),
      .br_wr(br_wr), .br_data(br_data), .redirect(redirect),
      .fault_valid(fault_valid), .fault_cause(fault_cause)
   );

   typedef struct {
      logic wbv; logic [3:0] wbi; logic [31:0] wbd; logic wbt;
      logic mv; logic ms; logic [31:0] ma; logic [31:0] sd; logic st;
      logic brw; logic [31:0] brd; logic rdr; logic fv; logic [1:0] fc;
      logic [7:0] pv; string req;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0, n_bad = 0;
   bit   done = 0;

   // bench model of architectural state, built from the requirements
   logic [31:0] m_reg [NREG];
   logic        m_tag [NREG];
   logic [31:0] m_sd  [NSLOT];
   logic        m_st  [NSLOT];
   logic [7:0]  m_pred;

   task automatic fail_line(string req, string what, logic [127:0] act, logic [127:0] expv);
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
   endtask

   task automatic apply(input logic [3:0] code, input logic [3:0] rd, input logic [3:0] rs1,
                        input logic [3:0] rs2, input logic relax, input logic [2:0] pt,
                        input logic [2:0] pf, input logic [1:0] slot,
                        input logic [31:0] ldd, input logic ldt, input string req);
      exp_t e;
      logic [31:0] a, b, r;
      logic ta, tb, rt, wr, c;
      a = m_reg[rs1]; ta = m_tag[rs1]; b = m_reg[rs2]; tb = m_tag[rs2];
      e = '{wbv:0, wbi:rd, wbd:0, wbt:0, mv:0, ms:0, ma:0, sd:0, st:0,
            brw:0, brd:0, rdr:0, fv:0, fc:0, pv:m_pred, req:req};
      wr = 0; r = 0; rt = ta | tb;
      case (code)
         4'd0: begin r = a + b; wr = 1; end
         4'd1: begin r = (rs1 == rs2) ? 0 : a - b; rt = (rs1 == rs2) ? 0 : rt; wr = 1; end
         4'd2: begin r = a & b; wr = 1; end
         4'd3: begin r = a | b; wr = 1; end
         4'd4: begin r = (rs1 == rs2) ? 0 : a ^ b; rt = (rs1 == rs2) ? 0 : rt; wr = 1; end
         4'd5, 4'd6: begin
            c = (code == 4'd5) ? (a == b) : (a < b);
            if ((ta | tb) && !relax) begin m_pred[pf] = 0; m_pred[pt] = 0; end
            else begin m_pred[pf] = !c; m_pred[pt] = c; end
            e.pv = m_pred;
         end
         4'd7: begin r = 0; rt = 1; wr = 1; end
         4'd8: begin r = a; rt = 0; wr = 1; end
         4'd9: begin
            if (ta && !relax) begin e.fv = 1; e.fc = 1; end
            else begin r = ldd; rt = ldt | ta; wr = 1; e.mv = 1; e.ma = a; end
         end
         4'd10: begin
            if (ta && !relax) begin e.fv = 1; e.fc = 1; end
            else begin e.mv = 1; e.ms = 1; e.ma = a; e.sd = b; e.st = tb; end
         end
         4'd11: begin
            if (ta) begin e.fv = 1; e.fc = 2; end
            else begin e.brw = 1; e.brd = a; end
         end
         4'd12: e.rdr = ta;
         4'd13: begin m_sd[slot] = a; m_st[slot] = ta; end
         4'd14: begin r = m_sd[slot]; rt = m_st[slot]; wr = 1; end
         default: ;
      endcase
      if (wr && rd != 0) begin
         e.wbv = 1; e.wbd = r; e.wbt = rt;
         m_reg[rd] = r; m_tag[rd] = rt;
      end
      exp_q.push_back(e);
      op_valid = 1; op_code = code; op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
      op_relax = relax; op_pd_t = pt; op_pd_f = pf; op_slot = slot;
      ld_data = ldd; ld_tag = ldt;
      @(negedge clk);
   endtask

   task automatic idle(input string req);
      exp_t e;
      e = '{wbv:0, wbi:0, wbd:0, wbt:0, mv:0, ms:0, ma:0, sd:0, st:0,
            brw:0, brd:0, rdr:0, fv:0, fc:0, pv:m_pred, req:req};
      exp_q.push_back(e);
      op_valid = 0;
      @(negedge clk);
   endtask

   // monitor: compare each expected item a quarter period after its capturing edge
   always @(posedge clk) begin
      #5;
      if (rst_n && exp_q.size() > 0) begin
         exp_t e;
         bit bad;
         e = exp_q.pop_front();
         n_vec++;
         bad = 0;
         if (wb_valid !== e.wbv || (e.wbv && (wb_idx !== e.wbi || wb_data !== e.wbd || wb_tag !== e.wbt))) begin
            fail_line(e.req, "writeback", {wb_valid, wb_idx, wb_data, wb_tag}, {e.wbv, e.wbi, e.wbd, e.wbt}); bad = 1;
         end
         if (mem_valid !== e.mv || (e.mv && (mem_store !== e.ms || mem_addr !== e.ma ||
             (e.ms && (st_data !== e.sd || st_tag !== e.st))))) begin
            fail_line(e.req, "memory", {mem_valid, mem_store, mem_addr, st_data, st_tag},
                      {e.mv, e.ms, e.ma, e.sd, e.st}); bad = 1;
         end
         if (br_wr !== e.brw || (e.brw && br_data !== e.brd)) begin
            fail_line(e.req, "branch", {br_wr, br_data}, {e.brw, e.brd}); bad = 1;
         end
         if (redirect !== e.rdr || fault_valid !== e.fv || fault_cause !== e.fc) begin
            fail_line(e.req, "redirect/fault", {redirect, fault_valid, fault_cause}, {e.rdr, e.fv, e.fc}); bad = 1;
         end
         if (pred_vec !== e.pv) begin
            fail_line(e.req, "predicates", pred_vec, e.pv); bad = 1;
         end
         if (bad) n_vec = n_vec; // failures already counted per item line
      end
   end

   initial begin
      for (int i = 0; i < NREG; i++) begin m_reg[i] = 0; m_tag[i] = 0; end
      for (int i = 0; i < NSLOT; i++) begin m_sd[i] = 0; m_st[i] = 0; end
      m_pred = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      n_vec++;
      if ({wb_valid, mem_valid, br_wr, redirect, fault_valid, fault_cause, pred_vec} !== '0)
         fail_line("R12", "reset state", {wb_valid, mem_valid, br_wr, redirect, fault_valid, fault_cause, pred_vec}, 0);

      apply(4'd7, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 settag");
      apply(4'd9, 4'd2, 0, 0, 0, 0, 0, 0, 32'h1234, 0, "R5 load clean");
      apply(4'd9, 4'd3, 0, 0, 0, 0, 0, 0, 32'h00FF, 0, "R5 load clean");
      apply(4'd9, 4'd4, 0, 0, 0, 0, 0, 0, 32'h0055, 1, "R5 load tainted data");
      apply(4'd0, 4'd5, 4'd2, 4'd3, 0, 0, 0, 0, 0, 0, "R1 add clean");
      apply(4'd0, 4'd6, 4'd2, 4'd4, 0, 0, 0, 0, 0, 0, "R1 add tainted");
      apply(4'd3, 4'd7, 4'd1, 4'd3, 0, 0, 0, 0, 0, 0, "R1 or tainted");
      apply(4'd2, 4'd8, 4'd3, 4'd2, 0, 0, 0, 0, 0, 0, "R1 and");
      apply(4'd4, 4'd8, 4'd4, 4'd4, 0, 0, 0, 0, 0, 0, "R2 self xor");
      apply(4'd1, 4'd9, 4'd6, 4'd6, 0, 0, 0, 0, 0, 0, "R2 self sub");
      apply(4'd1, 4'd10, 4'd2, 4'd3, 0, 0, 0, 0, 0, 0, "R1 sub");
      apply(4'd5, 0, 4'd2, 4'd2, 0, 3'd1, 3'd2, 0, 0, 0, "R3 cmpeq clean");
      apply(4'd6, 0, 4'd3, 4'd2, 0, 3'd3, 3'd4, 0, 0, 0, "R3 cmplt clean");
      apply(4'd6, 0, 4'd4, 4'd2, 0, 3'd3, 3'd4, 0, 0, 0, "R3 cmplt tainted kills");
      apply(4'd6, 0, 4'd4, 4'd2, 1, 3'd5, 3'd6, 0, 0, 0, "R4 cmplt relaxed");
      apply(4'd5, 0, 4'd4, 4'd12, 1, 3'd7, 3'd0, 0, 0, 0, "R4 cmpeq relaxed");
      apply(4'd9, 4'd11, 4'd4, 0, 0, 0, 0, 0, 32'hAAAA, 0, "R5 R11 load tainted addr");
      apply(4'd3, 4'd12, 4'd11, 0, 0, 0, 0, 0, 0, 0, "R11 faulting load wrote nothing");
      apply(4'd9, 4'd11, 4'd4, 0, 1, 0, 0, 0, 32'hBEEF, 0, "R5 load relaxed addr");
      apply(4'd10, 0, 4'd2, 4'd4, 0, 0, 0, 0, 0, 0, "R5 store");
      apply(4'd10, 0, 4'd4, 4'd2, 0, 0, 0, 0, 0, 0, "R5 R11 store tainted addr");
      apply(4'd11, 0, 4'd2, 0, 0, 0, 0, 0, 0, 0, "R6 movbr clean");
      apply(4'd11, 0, 4'd4, 0, 1, 0, 0, 0, 0, 0, "R6 R11 movbr tainted");
      apply(4'd8, 4'd12, 4'd4, 0, 0, 0, 0, 0, 0, 0, "R7 clrtag");
      apply(4'd12, 0, 4'd4, 0, 0, 0, 0, 0, 0, 0, "R8 check tainted");
      apply(4'd12, 0, 4'd2, 0, 0, 0, 0, 0, 0, 0, "R8 check clean");
      apply(4'd13, 0, 4'd6, 0, 0, 0, 0, 2'd1, 0, 0, "R9 spill");
      apply(4'd9, 4'd13, 0, 0, 0, 0, 0, 2'd1, 32'h7, 0, "R9 load ignores slot");
      apply(4'd14, 4'd14, 0, 0, 0, 0, 0, 2'd1, 32'hFFFF, 1, "R9 fill");
      apply(4'd14, 4'd15, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R9 fill empty slot");
      apply(4'd0, 4'd0, 4'd2, 4'd3, 0, 0, 0, 0, 0, 0, "R10 write r0");
      apply(4'd7, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 settag r0");
      apply(4'd3, 4'd15, 4'd0, 4'd0, 0, 0, 0, 0, 0, 0, "R10 read r0");
      idle("R12 idle");
      apply(4'd0, 4'd5, 4'd6, 4'd11, 0, 0, 0, 0, 0, 0, "R1 add two tainted");
      idle("R12 idle");
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule